// File: doc/BRIEF.md
# Longword Compare Execute Unit

This block decodes and runs the 32-bit register compare operation of a small CPU core. Instruction bytes arrive one per cycle over a valid/ready byte stream. Two encodings are accepted. One compares a register against a register. The other compares a 32-bit immediate, carried in the stream, against a register.

The unit drives two read indices into an external eight-entry file of 32-bit general registers. It subtracts the source from the destination and updates five condition flags: half-borrow, negative, zero, overflow and borrow. No register is ever written. A one-cycle `done` pulse marks the end of a compare. A one-cycle `illegal` pulse marks an encoding the unit does not recognise.

The three remaining condition-register bits are not touched by the unit. They are passed from an input straight to the assembled condition-register output.

Top module: `cmpl_exec_unit`

## Requirements
- R1: The register form is two bytes. The first byte is 0x1F. The second byte has bit 7 = 1, the source index in bits 6:4, bit 3 = 0 and the destination index in bits 2:0. The unit compares destination minus source, and `done` is high in the cycle after the first clock edge that follows acceptance of the second byte.
- R2: The immediate form is six bytes. The first byte is 0x7A. The second byte has bits 7:3 = 00100 and the destination index in bits 2:0. Four immediate bytes follow, most significant first. `done` is high after the third clock edge that follows acceptance of the last immediate byte.
- R3: Flag C (`ccr_out` bit 0) is set exactly when the 32-bit subtraction borrows out of bit 31, that is, when the destination is less than the source as unsigned numbers.
- R4: Flag H (`ccr_out` bit 5) is set exactly when the subtraction borrows out of bit 27, that is, when destination bits 27:0 are less than source bits 27:0 as unsigned numbers.
- R5: Flag N (`ccr_out` bit 3) equals bit 31 of the result. Flag Z (`ccr_out` bit 2) is set exactly when all 32 result bits are zero.
- R6: Flag V (`ccr_out` bit 1) is set exactly when the subtraction overflows in signed two's complement. This happens when the operands differ in sign and the result's sign differs from the destination's.
- R7: Each of the following raises `illegal` for one cycle, in the cycle after the offending byte is accepted:
  - a first byte other than 0x1F or 0x7A;
  - a second byte that breaks the fixed bits of its form.

  The flags stay unchanged and the next byte is treated as a first byte.
- R8: `byte_ready` is low during the execute cycles. It is high in the `done` cycle, so the next instruction's first byte can be accepted in that same cycle.
- R9: `ccr_out` bits 7, 6 and 4 always equal `ccr_pass_in` bits 2, 1 and 0.
- R10: A synchronous active-high `rst` does all of the following:
  - clears the five flags, `done` and `illegal`;
  - discards any partly received instruction;
  - leaves `byte_ready` high.
- R11: The five flags change only at the clock edge that raises `done`. They hold during byte reception and during the execute cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Instruction byte present |
| byte_data | input | 8 | Instruction byte |
| byte_ready | output | 1 | Unit can take a byte this cycle |
| rf_src_idx | output | 3 | Source register read index |
| rf_dst_idx | output | 3 | Destination register read index |
| rf_src_data | input | 32 | Source register contents |
| rf_dst_data | input | 32 | Destination register contents |
| ccr_pass_in | input | 3 | Condition bits carried through, {I, UI, U} |
| ccr_out | output | 8 | Condition register {I, UI, H, U, N, Z, V, C} |
| done | output | 1 | Compare finished, flags updated |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The end of one compare and the acceptance of the next instruction's opcode byte can fall in the same cycle. In that cycle `done` pulses while `byte_ready` is high. The bench provokes this by keeping `byte_valid` high across instruction boundaries, so each opcode waits through the stall and is taken in the `done` cycle. Every result is judged against a scoreboard entry that holds the exact cycle `done` is due, counted from the acceptance of the final byte. A later instruction that starts a cycle early or late therefore shows up as a latency mismatch on its own result.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

   localparam int REG_IDX_W = 3;
   localparam logic [7:0] OPC_REG_FORM = 8'h1F;
   localparam logic [7:0] OPC_IMM_FORM = 8'h7A;
   localparam logic [4:0] IMM_SEL_PREFIX = 5'b00100;

   // condition register bit positions
   localparam int CCR_I  = 7;
   localparam int CCR_UI = 6;
   localparam int CCR_H  = 5;
   localparam int CCR_U  = 4;
   localparam int CCR_N  = 3;
   localparam int CCR_Z  = 2;
   localparam int CCR_V  = 1;
   localparam int CCR_C  = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REG_SEL,
      ST_IMM_SEL,
      ST_IMM_BYTES,
      ST_EXEC
   } dec_state_t;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } cmp_flags_t;

endpackage

// File: rtl/cmpl_byte_decoder.sv
module cmpl_byte_decoder
   import cmpl_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int REG_STATES = 1,
   parameter int IMM_STATES = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 byte_valid,
   input  logic [7:0]           byte_data,
   output logic                 byte_ready,
   output logic [REG_IDX_W-1:0] src_idx,
   output logic [REG_IDX_W-1:0] dst_idx,
   output logic                 use_imm,
   output logic [DATA_W-1:0]    imm_value,
   output logic                 exec_last,
   output logic                 bad_code
);

   localparam int IMM_BYTES = DATA_W / 8;
   localparam int BCNT_W    = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
   localparam int EXEC_MAX  = (IMM_STATES > REG_STATES) ? IMM_STATES : REG_STATES;
   localparam int ECNT_W    = (EXEC_MAX > 1) ? $clog2(EXEC_MAX) : 1;

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("cmpl_byte_decoder: DATA_W must be a multiple of 8, at least 16");
   end
   if (REG_STATES < 1 || IMM_STATES < 1) begin : g_bad_states
      $error("cmpl_byte_decoder: execute state counts must be at least 1");
   end

   dec_state_t          state_q;
   logic [BCNT_W-1:0]   bcnt_q;
   logic [ECNT_W-1:0]   ecnt_q;
   logic                take;

   assign byte_ready = (state_q != ST_EXEC);
   assign take       = byte_valid & byte_ready;
   assign exec_last  = (state_q == ST_EXEC) && (ecnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         bcnt_q    <= '0;
         ecnt_q    <= '0;
         src_idx   <= '0;
         dst_idx   <= '0;
         use_imm   <= 1'b0;
         imm_value <= '0;
         bad_code  <= 1'b0;
      end else begin
         bad_code <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (take) begin
                  if (byte_data == OPC_REG_FORM) begin
                     state_q <= ST_REG_SEL;
                  end else if (byte_data == OPC_IMM_FORM) begin
                     state_q <= ST_IMM_SEL;
                  end else begin
                     bad_code <= 1'b1;
                  end
               end
            end
            ST_REG_SEL: begin
               if (take) begin
                  if (byte_data[7] && !byte_data[3]) begin
                     src_idx <= byte_data[6:4];
                     dst_idx <= byte_data[2:0];
                     use_imm <= 1'b0;
                     ecnt_q  <= ECNT_W'(REG_STATES - 1);
                     state_q <= ST_EXEC;
                  end else begin
                     bad_code <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               end
            end
            ST_IMM_SEL: begin
               if (take) begin
                  if (byte_data[7:3] == IMM_SEL_PREFIX) begin
                     dst_idx <= byte_data[2:0];
                     use_imm <= 1'b1;
                     bcnt_q  <= '0;
                     state_q <= ST_IMM_BYTES;
                  end else begin
                     bad_code <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               end
            end
            ST_IMM_BYTES: begin
               if (take) begin
                  imm_value <= {imm_value[DATA_W-9:0], byte_data};
                  if (bcnt_q == BCNT_W'(IMM_BYTES - 1)) begin
                     ecnt_q  <= ECNT_W'(IMM_STATES - 1);
                     state_q <= ST_EXEC;
                  end else begin
                     bcnt_q <= bcnt_q + 1'b1;
                  end
               end
            end
            ST_EXEC: begin
               if (ecnt_q == '0) begin
                  state_q <= ST_IDLE;
               end else begin
                  ecnt_q <= ecnt_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cmpl_flag_unit.sv
module cmpl_flag_unit
   import cmpl_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int HALF_POS = 27
) (
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   output cmp_flags_t        flags
);

   if (HALF_POS < 0 || HALF_POS >= DATA_W) begin : g_bad_half
      $error("cmpl_flag_unit: HALF_POS must lie inside the data word");
   end

   logic [DATA_W:0]   wide;
   logic [DATA_W-1:0] diff;
   logic              half_borrow;

   assign wide = {1'b0, minuend} - {1'b0, subtrahend};
   assign diff = wide[DATA_W-1:0];

   // borrow into bit HALF_POS+1 recovered from the full difference
   if (HALF_POS == DATA_W - 1) begin : g_half_is_top
      assign half_borrow = wide[DATA_W];
   end else begin : g_half_inner
      assign half_borrow = minuend[HALF_POS+1] ^ subtrahend[HALF_POS+1] ^ diff[HALF_POS+1];
   end

   always_comb begin
      flags.c = wide[DATA_W];
      flags.h = half_borrow;
      flags.n = diff[DATA_W-1];
      flags.z = (diff == '0);
      flags.v = (minuend[DATA_W-1] ^ subtrahend[DATA_W-1]) &
                (minuend[DATA_W-1] ^ diff[DATA_W-1]);
   end

endmodule

// File: rtl/cmpl_exec_unit.sv
module cmpl_exec_unit
   import cmpl_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int HALF_POS   = 27,
   parameter int REG_STATES = 1,
   parameter int IMM_STATES = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 byte_valid,
   input  logic [7:0]           byte_data,
   output logic                 byte_ready,
   output logic [REG_IDX_W-1:0] rf_src_idx,
   output logic [REG_IDX_W-1:0] rf_dst_idx,
   input  logic [DATA_W-1:0]    rf_src_data,
   input  logic [DATA_W-1:0]    rf_dst_data,
   input  logic [2:0]           ccr_pass_in,
   output logic [7:0]           ccr_out,
   output logic                 done,
   output logic                 illegal
);

   logic              use_imm;
   logic [DATA_W-1:0] imm_value;
   logic [DATA_W-1:0] operand_src;
   logic              exec_last;
   logic              bad_code;
   cmp_flags_t        flags_new;
   cmp_flags_t        flags_q;
   logic              done_q;

   cmpl_byte_decoder #(
      .DATA_W     (DATA_W),
      .REG_STATES (REG_STATES),
      .IMM_STATES (IMM_STATES)
   ) u_decoder (
      .clk        (clk),
      .rst        (rst),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .byte_ready (byte_ready),
      .src_idx    (rf_src_idx),
      .dst_idx    (rf_dst_idx),
      .use_imm    (use_imm),
      .imm_value  (imm_value),
      .exec_last  (exec_last),
      .bad_code   (bad_code)
   );

   assign operand_src = use_imm ? imm_value : rf_src_data;

   cmpl_flag_unit #(
      .DATA_W   (DATA_W),
      .HALF_POS (HALF_POS)
   ) u_flags (
      .minuend    (rf_dst_data),
      .subtrahend (operand_src),
      .flags      (flags_new)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= exec_last;
         if (exec_last) begin
            flags_q <= flags_new;
         end
      end
   end

   always_comb begin
      ccr_out        = '0;
      ccr_out[CCR_I] = ccr_pass_in[2];
      ccr_out[CCR_UI]= ccr_pass_in[1];
      ccr_out[CCR_U] = ccr_pass_in[0];
      ccr_out[CCR_H] = flags_q.h;
      ccr_out[CCR_N] = flags_q.n;
      ccr_out[CCR_Z] = flags_q.z;
      ccr_out[CCR_V] = flags_q.v;
      ccr_out[CCR_C] = flags_q.c;
   end

   assign done    = done_q;
   assign illegal = bad_code;

endmodule

// File: rtl/cmpl_exec_unit_chk.sv
module cmpl_exec_unit_chk (
   input logic       clk,
   input logic       rst,
   input logic       byte_ready,
   input logic [7:0] ccr_out,
   input logic       done,
   input logic       illegal
);

   logic [4:0] fl;
   assign fl = {ccr_out[5], ccr_out[3:0]};

   assert_done_not_illegal_R7: assert property (@(posedge clk) disable iff (rst)
      !(done && illegal));

   assert_illegal_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
      (illegal && !$past(rst)) |-> $stable(fl));

   assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!done && !$past(rst)) |-> $stable(fl));

   assert_ready_on_done_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> byte_ready);

   assert_stall_before_done_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> !$past(byte_ready));

   assert_zero_clean_R5: assert property (@(posedge clk) disable iff (rst)
      (done && ccr_out[2]) |-> !(ccr_out[5] || ccr_out[3] || ccr_out[1] || ccr_out[0]));

endmodule

bind cmpl_exec_unit cmpl_exec_unit_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .byte_ready (byte_ready),
   .ccr_out    (ccr_out),
   .done       (done),
   .illegal    (illegal)
);

// File: tb/cmpl_exec_unit_bench.sv
`timescale 1ns/1ps
module cmpl_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        byte_ready;
   logic [2:0]  rf_src_idx, rf_dst_idx;
   logic [31:0] rf_src_data, rf_dst_data;
   logic [2:0]  ccr_pass_in = 3'b000;
   logic [7:0]  ccr_out;
   logic        done, illegal;

   logic [31:0] regs [8];
   int          cyc = 0;
   int          n_checks = 0;
   int          n_fail = 0;
   logic [4:0]  model_fl = '0;

   int          q_kind [$];
   int          q_cyc  [$];
   logic [4:0]  q_fl   [$];
   string       q_tag  [$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign rf_src_data = regs[rf_src_idx];
   assign rf_dst_data = regs[rf_dst_idx];

   cmpl_exec_unit u_cmpl_exec_unit (
      .clk (clk), .rst (rst),
      .byte_valid (byte_valid), .byte_data (byte_data), .byte_ready (byte_ready),
      .rf_src_idx (rf_src_idx), .rf_dst_idx (rf_dst_idx),
      .rf_src_data (rf_src_data), .rf_dst_data (rf_dst_data),
      .ccr_pass_in (ccr_pass_in), .ccr_out (ccr_out),
      .done (done), .illegal (illegal)
   );

   function automatic logic [4:0] out_flags();
      return {ccr_out[5], ccr_out[3], ccr_out[2], ccr_out[1], ccr_out[0]};
   endfunction

   // reference: {H, N, Z, V, C}
   function automatic logic [4:0] ref_flags(input logic [31:0] d, input logic [31:0] s);
      logic [32:0] w;
      logic [28:0] lo;
      logic [31:0] r;
      w  = {1'b0, d} - {1'b0, s};
      lo = {1'b0, d[27:0]} - {1'b0, s[27:0]};
      r  = w[31:0];
      return {lo[28], r[31], (r == 32'd0), (d[31] != s[31]) && (r[31] != d[31]), w[32]};
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // called at a negedge; returns at the negedge after the accepting edge
   task automatic send_byte(input logic [7:0] b, output int acc);
      byte_valid = 1'b1;
      byte_data  = b;
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      acc = cyc;
      byte_valid = 1'b0;
   endtask

   task automatic push(input int kind, input int at, input logic [4:0] fl, input string tag);
      q_kind.push_back(kind);
      q_cyc.push_back(at);
      q_fl.push_back(fl);
      q_tag.push_back(tag);
   endtask

   task automatic do_reg(input int s, input int d, input string tag);
      int acc;
      logic [4:0] e;
      send_byte(8'h1F, acc);
      send_byte({1'b1, 3'(s), 1'b0, 3'(d)}, acc);
      e = ref_flags(regs[d], regs[s]);
      push(0, acc + 1, e, tag);
      model_fl = e;
   endtask

   task automatic do_imm(input logic [31:0] val, input int d, input string tag);
      int acc;
      logic [4:0] e;
      send_byte(8'h7A, acc);
      send_byte({5'b00100, 3'(d)}, acc);
      for (int i = 3; i >= 0; i--) send_byte(val[i*8 +: 8], acc);
      // first execute cycle: stalled, flags still old
      check(byte_ready == 1'b0, "R8 ready low in execute", byte_ready, 0);
      check(out_flags() == model_fl, "R11 flags hold before done", out_flags(), model_fl);
      e = ref_flags(regs[d], val);
      push(0, acc + 3, e, tag);
      model_fl = e;
   endtask

   task automatic do_bad2(input logic [7:0] b1, input logic [7:0] b2, input string tag);
      int acc;
      send_byte(b1, acc);
      send_byte(b2, acc);
      push(1, acc, model_fl, tag);
   endtask

   task automatic do_bad1(input logic [7:0] b1, input string tag);
      int acc;
      send_byte(b1, acc);
      push(1, acc, model_fl, tag);
   endtask

   // scoreboard monitor, sampled after the negedge driver activity
   always @(negedge clk) begin
      #0.5;
      if (!rst && (done || illegal)) begin
         if (q_kind.size() == 0) begin
            check(1'b0, "R7 unexpected result pulse", {done, illegal}, 0);
         end else begin
            int k, at;
            logic [4:0] fl;
            string tag;
            k = q_kind.pop_front();
            at = q_cyc.pop_front();
            fl = q_fl.pop_front();
            tag = q_tag.pop_front();
            check(done == (k == 0) && illegal == (k == 1), tag, {done, illegal}, k == 0 ? 2 : 1);
            check(cyc == at, {tag, " latency"}, cyc, at);
            check(out_flags() == fl, {tag, " flags"}, out_flags(), fl);
            check({ccr_out[7], ccr_out[6], ccr_out[4]} == ccr_pass_in, "R9 pass-through bits",
                  {ccr_out[7], ccr_out[6], ccr_out[4]}, ccr_pass_in);
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      regs[0] = 32'h8000_0000; regs[1] = 32'h0000_0001;
      regs[2] = 32'h0000_0000; regs[3] = 32'h1234_5678;
      regs[4] = 32'h1234_5678; regs[5] = 32'h1000_0000;
      regs[6] = 32'h7FFF_FFFF; regs[7] = 32'hFFFF_FFFF;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(out_flags() == 5'b0, "R10 flags clear after reset", out_flags(), 0);
      check(byte_ready == 1'b1, "R10 ready after reset", byte_ready, 1);
      check(done == 1'b0, "R10 done low after reset", done, 0);
      check(illegal == 1'b0, "R10 illegal low after reset", illegal, 0);

      // register form, back to back
      ccr_pass_in = 3'b101;
      do_reg(1, 0, "R6 R1 min-neg minus one");
      do_reg(1, 2, "R3 R5 zero minus one");
      do_reg(4, 3, "R5 R1 equal operands");
      do_reg(1, 5, "R4 R1 borrow at bit 27 only");
      do_reg(7, 6, "R6 R3 max-pos minus minus-one");
      do_reg(7, 7, "R5 R1 same register");
      // immediate form, back to back
      ccr_pass_in = 3'b010;
      do_imm(32'h0000_0001, 2, "R3 R2 imm zero minus one");
      do_imm(32'h0000_0001, 0, "R6 R2 imm min-neg minus one");
      do_imm(32'h1234_5678, 3, "R5 R2 imm byte order equal");
      do_imm(32'h0800_0000, 5, "R4 R2 imm half borrow");
      do_reg(0, 2, "R6 R1 zero minus min-neg");
      // bad encodings, flags must hold
      ccr_pass_in = 3'b111;
      do_bad2(8'h1F, 8'h88, "R7 reg form bit3 set");
      do_bad2(8'h1F, 8'h08, "R7 reg form bit7 clear");
      do_bad2(8'h7A, 8'h28, "R7 imm form bit3 set");
      do_bad2(8'h7A, 8'hA1, "R7 imm form wrong prefix");
      do_bad1(8'h55, "R7 unknown first byte");
      do_reg(3, 6, "R1 R7 good after illegal");
      repeat (6) @(negedge clk);

      // reset in the middle of an immediate instruction
      begin
         int acc;
         send_byte(8'h7A, acc);
         send_byte(8'h22, acc);
         send_byte(8'hAB, acc);
      end
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_fl = '0;
      @(negedge clk);
      check(out_flags() == 5'b0, "R10 flags clear on mid reset", out_flags(), 0);
      check(byte_ready == 1'b1, "R10 ready after mid reset", byte_ready, 1);
      ccr_pass_in = 3'b000;
      do_reg(1, 2, "R10 R3 fresh instruction after reset");
      repeat (8) @(negedge clk);
      check(q_kind.size() == 0, "R1 R2 all results seen", q_kind.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule